// File: doc/BRIEF.md
# ROM Zone Protection Command Controller

This block is the byte-level command engine of a small serial EEPROM. A bus front end, outside this block, turns the wire into events: a start, a stop, a received byte with a valid strobe, and a request for the acknowledge slot. The engine decodes three command sequences from those events. The first programs a zone protection register. The second locks all zone registers for good. The third is a plain memory write, which is refused when its target lies in a protected zone. For every byte it gives an ACK or NACK verdict.

The memory is 128 bytes, split into four zones of 32 bytes each. When a zone register is set, its zone becomes read-only. A command only has an effect when a stop follows a complete and accepted sequence. That stop commits the change and starts a self-timed busy window, and the engine turns away all new traffic until the window ends. The array storage sits outside this block. The engine drives a one-cycle write enable together with the address and data.

Top module: `zoneGuardTop`

## Requirements
- R1: The first byte after a start is decoded as opcode in bits 7:4, slave address in bits 3:1 and a read/write flag in bit 0. If the slave address differs from `strap`, the flag is 1, or the opcode is not 0111b, 0001b or 1010b, that byte is NACKed. Every later byte is then NACKed until the next start.
- R2: Opcode 0111b (zone register write) ACKs the header and the register address byte. The data byte is ACKed only if it equals FFh, the register address is below 4 and the registers are not frozen. Otherwise it is NACKed.
- R3: A stop right after an ACKed zone data byte sets bit n of `zoneRo` (n = register address), one cycle after the stop. Zone n covers memory addresses n*32 to n*32+31. Zone bits are never cleared except by reset.
- R4: Opcode 0001b (freeze) gets its header ACKed while `frozen` is 0 and NACKed once `frozen` is 1.
- R5: After an ACKed freeze header, the next byte must be 55h and the one after it AAh. Each matching byte is ACKed. Any other value is NACKed and the freeze is dropped.
- R6: `frozen` rises one cycle after a stop that directly follows the ACKed AAh byte. A stop at any earlier point leaves it at 0. Once set, `frozen` stays 1 and `zoneRo` no longer changes.
- R7: Opcode 1010b (memory write) ACKs the header and the word address byte whether or not the address is protected.
- R8: A memory data byte whose address (bits 6:0) lies in a protected zone is NACKed and causes no write. Otherwise it is ACKed, and a following stop gives a one-cycle `memWe` pulse one cycle later, with `memAddr` = address bits 6:0 and `memData` = the data byte.
- R9: Each commit raises `busy` for exactly BUSY_CYCLES cycles, starting one cycle after the stop. While `busy` is high, starts are ignored and every byte is NACKed.
- R10: A byte that arrives after a completed sequence, before the stop, is NACKed and cancels the pending commit.
- R11: One cycle after `ackReq`, `ackStrobe` pulses. At that point `ackNack` holds the verdict for the last byte: 0 means ACK, 1 means NACK.
- R12: After reset, `zoneRo` is 0, `frozen` is 0, `busy` is 0, `memWe` is 0 and `ackNack` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| strap | input | 3 | Slave address strap |
| evStart | input | 1 | Start event pulse |
| evStop | input | 1 | Stop event pulse |
| rxValid | input | 1 | Received byte valid pulse |
| rxByte | input | 8 | Received byte |
| ackReq | input | 1 | Acknowledge slot request |
| ackStrobe | output | 1 | Verdict valid, one cycle after ackReq |
| ackNack | output | 1 | Verdict: 0 ACK, 1 NACK |
| zoneRo | output | 4 | Per-zone read-only flags |
| frozen | output | 1 | Zone registers locked |
| busy | output | 1 | Self-timed write cycle running |
| memWe | output | 1 | Array write enable pulse |
| memAddr | output | 7 | Array write address |
| memData | output | 8 | Array write data |

## Verification
The assertions assume that the front end gives one-cycle event pulses and never raises a start, a stop and a byte strobe in the same cycle. They also assume that an acknowledge request always comes after the byte it answers. The bench drives each event through its own task, one pulse per cycle, and always requests the verdict in the cycle after the byte. Traffic during the busy window is sent on purpose, so that the ignore and NACK behaviour is exercised under the same rules.

// File: rtl/zoneGuardPkg.sv
package zoneGuardPkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HDR,
    ST_ZADDR, ST_ZDATA, ST_ZARM,
    ST_FADDR, ST_FDATA, ST_FARM,
    ST_MADDR, ST_MDATA, ST_MARM,
    ST_DEAD
  } cmdState_e;

  localparam logic [3:0] OPC_ZONE   = 4'b0111;
  localparam logic [3:0] OPC_FREEZE = 4'b0001;
  localparam logic [3:0] OPC_MEM    = 4'b1010;

  localparam logic [7:0] FRZ_KEY_A    = 8'h55;
  localparam logic [7:0] FRZ_KEY_B    = 8'hAA;
  localparam logic [7:0] ZONE_SET_VAL = 8'hFF;

  typedef struct packed {
    logic loadAddr;
    logic loadData;
    logic commitZone;
    logic commitFreeze;
    logic commitMem;
  } ctrlStrb_t;

endpackage

// File: rtl/zoneGuardCtrl.sv
module zoneGuardCtrl
  import zoneGuardPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] strap,
  input  logic       evStart,
  input  logic       evStop,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       ackReq,
  input  logic       frozen,
  input  logic       busy,
  input  logic       addrProt,
  input  logic       zoneAddrOk,
  output ctrlStrb_t  strb,
  output logic       ackStrobe,
  output logic       ackNack
);

  cmdState_e state, stateNxt;
  logic      nackReg, nackNxt;

  logic [3:0] hdrOpc;
  logic [2:0] hdrSlv;
  logic       hdrRd;
  assign hdrOpc = rxByte[7:4];
  assign hdrSlv = rxByte[3:1];
  assign hdrRd  = rxByte[0];

  always_comb begin
    stateNxt = state;
    nackNxt  = nackReg;
    strb     = '0;
    if (busy) begin
      if (rxValid) nackNxt = 1'b1;
    end else if (evStart) begin
      stateNxt = ST_HDR;
    end else if (evStop) begin
      unique case (state)
        ST_ZARM: strb.commitZone   = 1'b1;
        ST_FARM: strb.commitFreeze = 1'b1;
        ST_MARM: strb.commitMem    = 1'b1;
        default: ;
      endcase
      stateNxt = ST_IDLE;
    end else if (rxValid) begin
      nackNxt  = 1'b1;
      stateNxt = ST_DEAD;
      unique case (state)
        ST_HDR: begin
          if (hdrSlv == strap && !hdrRd) begin
            if (hdrOpc == OPC_ZONE) begin
              nackNxt = 1'b0; stateNxt = ST_ZADDR;
            end else if (hdrOpc == OPC_FREEZE && !frozen) begin
              nackNxt = 1'b0; stateNxt = ST_FADDR;
            end else if (hdrOpc == OPC_MEM) begin
              nackNxt = 1'b0; stateNxt = ST_MADDR;
            end
          end
        end
        ST_ZADDR: begin
          nackNxt = 1'b0; strb.loadAddr = 1'b1; stateNxt = ST_ZDATA;
        end
        ST_ZDATA: begin
          if (rxByte == ZONE_SET_VAL && zoneAddrOk && !frozen) begin
            nackNxt = 1'b0; stateNxt = ST_ZARM;
          end
        end
        ST_FADDR: begin
          if (rxByte == FRZ_KEY_A) begin
            nackNxt = 1'b0; stateNxt = ST_FDATA;
          end
        end
        ST_FDATA: begin
          if (rxByte == FRZ_KEY_B) begin
            nackNxt = 1'b0; stateNxt = ST_FARM;
          end
        end
        ST_MADDR: begin
          nackNxt = 1'b0; strb.loadAddr = 1'b1; stateNxt = ST_MDATA;
        end
        ST_MDATA: begin
          if (!addrProt) begin
            nackNxt = 1'b0; strb.loadData = 1'b1; stateNxt = ST_MARM;
          end else begin
            stateNxt = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      nackReg   <= 1'b1;
      ackStrobe <= 1'b0;
    end else begin
      state     <= stateNxt;
      nackReg   <= nackNxt;
      ackStrobe <= ackReq;
    end
  end

  assign ackNack = nackReg;

  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |=> ackStrobe); // R11
  AST_BUSY_BYTE_NACK: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rxValid) |=> ackNack); // R9
  AST_FROZEN_FREEZE_NACK: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && rxValid && !evStart && !evStop && state == ST_HDR &&
     rxByte[7:4] == OPC_FREEZE) |=> ackNack); // R4

endmodule

// File: rtl/zoneGuardDatapath.sv
module zoneGuardDatapath
  import zoneGuardPkg::*;
#(
  parameter int MEM_AW      = 7,
  parameter int ZONE_CNT    = 4,
  parameter int BUSY_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrb_t           strb,
  input  logic [7:0]          rxByte,
  output logic                addrProt,
  output logic                zoneAddrOk,
  output logic [ZONE_CNT-1:0] zoneRo,
  output logic                frozen,
  output logic                busy,
  output logic                memWe,
  output logic [MEM_AW-1:0]   memAddr,
  output logic [7:0]          memData
);

  localparam int         ZONE_W     = $clog2(ZONE_CNT);
  localparam int         CNT_W      = $clog2(BUSY_CYCLES + 1);
  localparam logic [7:0] ZONE_CNT_B = 8'(ZONE_CNT);

  logic [7:0]       addrReg;
  logic [7:0]       dataReg;
  logic [CNT_W-1:0] busyCnt;
  logic [ZONE_W-1:0] memZone;

  assign memZone    = addrReg[MEM_AW-1 -: ZONE_W];
  assign addrProt   = zoneRo[memZone];
  assign zoneAddrOk = (addrReg < ZONE_CNT_B);
  assign busy       = (busyCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      if (strb.loadAddr) addrReg <= rxByte;
      if (strb.loadData) dataReg <= rxByte;
    end
  end

  for (genvar z = 0; z < ZONE_CNT; z++) begin : gZone
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        zoneRo[z] <= 1'b0;
      else if (strb.commitZone && addrReg[ZONE_W-1:0] == ZONE_W'(z))
        zoneRo[z] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frozen  <= 1'b0;
      busyCnt <= '0;
      memWe   <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      if (strb.commitFreeze) frozen <= 1'b1;
      if (strb.commitZone || strb.commitFreeze || strb.commitMem)
        busyCnt <= CNT_W'(BUSY_CYCLES);
      else if (busy)
        busyCnt <= busyCnt - 1'b1;
      memWe <= strb.commitMem;
      if (strb.commitMem) begin
        memAddr <= addrReg[MEM_AW-1:0];
        memData <= dataReg;
      end
    end
  end

  AST_FROZEN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    frozen |=> frozen); // R6
  AST_FROZEN_LOCKS_ZONES: assert property (@(posedge clk) disable iff (!rstN)
    frozen |=> $stable(zoneRo)); // R6
  AST_ZONE_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((zoneRo & $past(zoneRo)) == $past(zoneRo))); // R3
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe); // R8
  AST_WE_UNPROTECTED: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !zoneRo[memAddr[MEM_AW-1 -: ZONE_W]]); // R8
  AST_WE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy); // R9

endmodule

// File: rtl/zoneGuardTop.sv
module zoneGuardTop
  import zoneGuardPkg::*;
#(
  parameter int MEM_AW      = 7,
  parameter int ZONE_CNT    = 4,
  parameter int BUSY_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          strap,
  input  logic                evStart,
  input  logic                evStop,
  input  logic                rxValid,
  input  logic [7:0]          rxByte,
  input  logic                ackReq,
  output logic                ackStrobe,
  output logic                ackNack,
  output logic [ZONE_CNT-1:0] zoneRo,
  output logic                frozen,
  output logic                busy,
  output logic                memWe,
  output logic [MEM_AW-1:0]   memAddr,
  output logic [7:0]          memData
);

  ctrlStrb_t strb;
  logic      addrProt;
  logic      zoneAddrOk;

  zoneGuardCtrl uCtrl (
    .clk(clk), .rstN(rstN), .strap(strap),
    .evStart(evStart), .evStop(evStop),
    .rxValid(rxValid), .rxByte(rxByte), .ackReq(ackReq),
    .frozen(frozen), .busy(busy),
    .addrProt(addrProt), .zoneAddrOk(zoneAddrOk),
    .strb(strb), .ackStrobe(ackStrobe), .ackNack(ackNack)
  );

  zoneGuardDatapath #(
    .MEM_AW(MEM_AW), .ZONE_CNT(ZONE_CNT), .BUSY_CYCLES(BUSY_CYCLES)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .rxByte(rxByte),
    .addrProt(addrProt), .zoneAddrOk(zoneAddrOk),
    .zoneRo(zoneRo), .frozen(frozen), .busy(busy),
    .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

endmodule

// File: tb/tb_zoneGuardTop.sv
module tb_zoneGuardTop;

  localparam int BUSY_CYCLES = 16;
  localparam logic [2:0] STRAP = 3'b101;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       evStart = 1'b0, evStop = 1'b0, rxValid = 1'b0, ackReq = 1'b0;
  logic [7:0] rxByte = '0;
  logic       ackStrobe, ackNack, frozen, busy, memWe;
  logic [3:0] zoneRo;
  logic [6:0] memAddr;
  logic [7:0] memData;

  int nChecks = 0;
  int nFails  = 0;
  bit expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  zoneGuardTop #(.BUSY_CYCLES(BUSY_CYCLES)) dut (
    .clk(clk), .rstN(rstN), .strap(STRAP),
    .evStart(evStart), .evStop(evStop), .rxValid(rxValid), .rxByte(rxByte),
    .ackReq(ackReq), .ackStrobe(ackStrobe), .ackNack(ackNack),
    .zoneRo(zoneRo), .frozen(frozen), .busy(busy),
    .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

  function automatic logic [7:0] hdr(input logic [3:0] opc);
    return {opc, STRAP, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected verdicts as the design returns them (R11)
  always @(negedge clk) begin
    if (ackStrobe) begin
      nChecks++;
      if (expQ.size() == 0) begin
        nFails++;
        $display("FAIL R11 actual=strobe expected=no strobe");
      end else begin
        bit e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (ackNack !== e) begin
          nFails++;
          $display("FAIL %s actual=%0b expected=%0b", t, ackNack, e);
        end
      end
    end
  end

  task automatic pulseStart;
    @(negedge clk) evStart = 1'b1;
    @(negedge clk) evStart = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expNack, input string tag);
    @(negedge clk) begin rxByte = b; rxValid = 1'b1; end
    @(negedge clk) begin rxValid = 1'b0; ackReq = 1'b1; expQ.push_back(expNack); tagQ.push_back(tag); end
    @(negedge clk) ackReq = 1'b0;
  endtask

  task automatic sendStop;
    @(negedge clk) evStop = 1'b1;
    @(negedge clk) evStop = 1'b0;
  endtask

  task automatic waitIdle;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  bit doneFlag = 0;

  initial begin
    #(20 * 100000);
    if (!doneFlag) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 zoneRo", zoneRo, 4'h0);
    chk("R12 frozen", frozen, 0);
    chk("R12 busy", busy, 0);
    chk("R12 memWe", memWe, 0);
    chk("R12 ackNack", ackNack, 1);

    // R7 R8 plain write in unprotected zone, R9 busy handling
    pulseStart;
    sendByte(hdr(4'b1010), 0, "R7 hdr");
    sendByte(8'h10, 0, "R7 addr");
    sendByte(8'h5A, 0, "R8 data");
    sendStop;
    chk("R8 memWe", memWe, 1);
    chk("R8 memAddr", memAddr, 7'h10);
    chk("R8 memData", memData, 8'h5A);
    chk("R9 busy", busy, 1);
    @(negedge clk);
    chk("R8 pulse", memWe, 0);
    pulseStart;
    sendByte(hdr(4'b1010), 1, "R9 busy hdr");
    chk("R9 still busy", busy, 1);
    waitIdle;
    sendByte(8'h00, 1, "R9 start ignored");

    // R1 slave mismatch then further bytes
    pulseStart;
    sendByte({4'b1010, 3'b011, 1'b0}, 1, "R1 slave");
    sendByte(8'h00, 1, "R1 dead");
    pulseStart;
    sendByte({4'b1010, STRAP, 1'b1}, 1, "R1 read flag");
    pulseStart;
    sendByte(hdr(4'b0110), 1, "R1 opcode");
    sendStop;
    chk("R1 no busy", busy, 0);

    // R2 R3 zone 1 set, with busy length count (R9)
    pulseStart;
    sendByte(hdr(4'b0111), 0, "R2 hdr");
    sendByte(8'h01, 0, "R2 addr");
    sendByte(8'hFF, 0, "R2 data");
    sendStop;
    chk("R3 zoneRo", zoneRo, 4'b0010);
    begin
      int n = 0;
      while (busy) begin n++; @(negedge clk); end
      chk("R9 busy length", n, BUSY_CYCLES);
    end

    // R2 bad data and bad address
    pulseStart;
    sendByte(hdr(4'b0111), 0, "R2 hdr2");
    sendByte(8'h02, 0, "R2 addr2");
    sendByte(8'hFE, 1, "R2 data not FF");
    sendStop;
    pulseStart;
    sendByte(hdr(4'b0111), 0, "R2 hdr3");
    sendByte(8'h05, 0, "R2 addr range");
    sendByte(8'hFF, 1, "R2 range nack");
    sendStop;
    chk("R2 zones unchanged", zoneRo, 4'b0010);
    chk("R2 no busy", busy, 0);

    // R7 R8 write into protected zone 1 (address 25h)
    pulseStart;
    sendByte(hdr(4'b1010), 0, "R7 hdr prot");
    sendByte(8'h25, 0, "R7 addr prot");
    sendByte(8'h33, 1, "R8 prot nack");
    sendStop;
    chk("R8 no write", memWe, 0);
    chk("R8 no busy", busy, 0);
    // high address bit ignored: A5h maps to 25h, still protected
    pulseStart;
    sendByte(hdr(4'b1010), 0, "R7 hdr hi");
    sendByte(8'hA5, 0, "R7 addr hi");
    sendByte(8'h44, 1, "R8 hi prot");

    // R10 extra byte cancels pending write
    pulseStart;
    sendByte(hdr(4'b1010), 0, "R10 hdr");
    sendByte(8'h02, 0, "R10 addr");
    sendByte(8'h11, 0, "R10 data");
    sendByte(8'h22, 1, "R10 extra");
    sendStop;
    chk("R10 no write", memWe, 0);
    chk("R10 no busy", busy, 0);

    // R5 wrong key
    pulseStart;
    sendByte(hdr(4'b0001), 0, "R4 hdr");
    sendByte(8'h54, 1, "R5 key A");
    sendStop;
    pulseStart;
    sendByte(hdr(4'b0001), 0, "R4 hdr2");
    sendByte(8'h55, 0, "R5 key A ok");
    sendByte(8'hAB, 1, "R5 key B");
    sendStop;
    chk("R5 not frozen", frozen, 0);
    // R6 early stop
    pulseStart;
    sendByte(hdr(4'b0001), 0, "R4 hdr3");
    sendByte(8'h55, 0, "R5 key A ok2");
    sendStop;
    chk("R6 early stop", frozen, 0);
    chk("R6 early no busy", busy, 0);
    // R6 full freeze
    pulseStart;
    sendByte(hdr(4'b0001), 0, "R4 hdr4");
    sendByte(8'h55, 0, "R5 key A ok3");
    sendByte(8'hAA, 0, "R5 key B ok");
    sendStop;
    chk("R6 frozen", frozen, 1);
    waitIdle;

    // R4 second freeze NACKed
    pulseStart;
    sendByte(hdr(4'b0001), 1, "R4 already frozen");
    // R2 R6 zone write after freeze
    pulseStart;
    sendByte(hdr(4'b0111), 0, "R2 hdr frozen");
    sendByte(8'h00, 0, "R2 addr frozen");
    sendByte(8'hFF, 1, "R2 frozen nack");
    sendStop;
    chk("R6 zones locked", zoneRo, 4'b0010);
    chk("R6 still frozen", frozen, 1);

    // R8 unprotected write still works, zone 3 top byte
    pulseStart;
    sendByte(hdr(4'b1010), 0, "R7 hdr late");
    sendByte(8'h7F, 0, "R7 addr late");
    sendByte(8'hC3, 0, "R8 data late");
    sendStop;
    chk("R8 late memWe", memWe, 1);
    chk("R8 late addr", memAddr, 7'h7F);
    chk("R8 late data", memData, 8'hC3);
    waitIdle;

    repeat (3) @(negedge clk);
    chk("R11 queue drained", expQ.size(), 0);
    doneFlag = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule